// File: doc/BRIEF.md
# Four-Way Carry Lookahead Generator

This block is the combinational node of a lookahead carry tree. It receives a generate/propagate pair from each of four adjacent groups, plus the carry entering the lowest group. From these it produces, in parallel, the carries that enter the three upper groups. It also condenses the four pairs into one section-level generate/propagate pair.

The section pair has the same meaning as a group pair. Identical units can therefore be stacked. Four units over 16 groups feed a fifth unit above them. The top unit returns the carries into sections 1 to 3, and those carries become the incoming carries of the lower units. With a blocking factor of four, each extra level multiplies the covered width by four. A 64-bit adder built from 4-bit groups needs two levels: the upper one supplies the carries at bits 16, 32 and 48.

The blocking factor is a parameter, `BLOCK`, with a default of 4. Every output is a sum of products over the inputs. None is formed by rippling through the lower carries.

Top module: `lah_gen`

## Requirements
- R1: For k = 1..BLOCK-1, bit k of `carry_o` equals `gen_i[k-1] | (prop_i[k-1] & c(k-1))`, where c(0) is `cin_i` and c(j) for j ≥ 1 is bit j of `carry_o`. Bit k is the carry entering group k.
- R2: If `gen_i[k-1]` is 1, bit k of `carry_o` is 1, whatever the other inputs are.
- R3: If `gen_i[k-1]` and `prop_i[k-1]` are both 0, bit k of `carry_o` is 0, whatever the other inputs are.
- R4: `sec_gen_o` equals the carry leaving group BLOCK-1 when the incoming carry is taken as 0.
- R5: `sec_prop_o` is 1 exactly when every bit of `prop_i` is 1.
- R6: `cin_i` has no effect on `sec_gen_o` or `sec_prop_o`.
- R7: With `gen_i` all 0 and `prop_i` all 1, every bit of `carry_o` equals `cin_i`.
- R8: A two-level tree works as follows. Four lower units take 16 group pairs. A fifth unit takes their section pairs and the tree's incoming carry. Its `carry_o` drives the incoming carries of lower units 1 to 3. Every carry in this tree equals the carry rippled through the 16 pairs. The top unit's section pair equals the 16-pair carry-out with an incoming carry of 0, together with the AND of all 16 propagates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gen_i | input | BLOCK | Generate signal of each group, bit 0 being the lowest group |
| prop_i | input | BLOCK | Propagate signal of each group (either the OR or the XOR form) |
| cin_i | input | 1 | Carry entering group 0 |
| carry_o | output | BLOCK-1 | Carries entering groups 1 to BLOCK-1, indexed [BLOCK-1:1] |
| sec_gen_o | output | 1 | Section generate over all BLOCK groups |
| sec_prop_o | output | 1 | Section propagate over all BLOCK groups |

## Verification
The assertions are immediate and sit inside combinational processes. They assume that the inputs are two-valued and settled when the process runs. A check is skipped whenever an input is unknown, which covers the time before the bench first drives the inputs. The inputs may set generate and propagate together, as the OR form of propagate does, and the stimulus covers those cases. At the single-unit level the stimulus goes through all 512 combinations of the inputs. At the tree level it drives 16-pair patterns from a shift-register sequence together with a full-propagate chain.

// File: rtl/lah_pkg.sv
package lah_pkg;
  localparam int unsigned LAH_BLOCK = 4;
  localparam int unsigned LAH_MIN_BLOCK = 2;
endpackage

// File: rtl/lah_sop.sv
// Flat sum-of-products carry across SPAN groups: one product per
// generating group plus one for the incoming carry, ORed together.
module lah_sop #(
  parameter int unsigned SPAN = 4
) (
  input  logic [SPAN-1:0] gen,
  input  logic [SPAN-1:0] prop,
  input  logic            cin,
  output logic            co
);
  logic [SPAN:0] term;

  // The incoming carry survives only if every group passes it on.
  assign term[SPAN] = cin & (&prop);

  for (genvar j = 0; j < SPAN; j++) begin : g_term
    if (j == SPAN - 1) begin : g_top
      assign term[j] = gen[j];
    end else begin : g_mid
      assign term[j] = gen[j] & (&prop[SPAN-1:j+1]);
    end
  end

  assign co = |term;
endmodule

// File: rtl/lah_carries.sv
// Parallel boundary carries: one flat term tree per group boundary.
module lah_carries #(
  parameter int unsigned BLOCK = 4
) (
  input  logic [BLOCK-1:0] gen,
  input  logic [BLOCK-1:0] prop,
  input  logic             cin,
  output logic [BLOCK-1:1] carry
);
  for (genvar k = 1; k < BLOCK; k++) begin : g_bnd
    lah_sop #(.SPAN(k)) u_sop (
      .gen  (gen[k-1:0]),
      .prop (prop[k-1:0]),
      .cin  (cin),
      .co   (carry[k])
    );

    logic prev_c;
    if (k == 1) begin : g_first
      assign prev_c = cin;
    end else begin : g_next
      assign prev_c = carry[k-1];
    end

    always_comb begin
      if (!$isunknown({gen, prop, cin, carry})) begin
        // R1: the flat carry agrees with one step of the ripple recurrence
        assert_ripple_step_R1 : assert (carry[k] == (gen[k-1] | (prop[k-1] & prev_c)))
          else $error("carry %0d breaks the ripple recurrence", k);
        // R2: a generating group always delivers a carry
        assert_gen_forces_R2 : assert (!gen[k-1] || carry[k])
          else $error("carry %0d low under generate", k);
        // R3: a group that neither generates nor propagates kills the carry
        assert_kill_clears_R3 : assert (gen[k-1] || prop[k-1] || !carry[k])
          else $error("carry %0d high under kill", k);
      end
    end
  end
endmodule

// File: rtl/lah_section.sv
// Section-level pair: carry-out of all groups with a zero carry-in, and
// the all-propagate term.
module lah_section #(
  parameter int unsigned BLOCK = 4
) (
  input  logic [BLOCK-1:0] gen,
  input  logic [BLOCK-1:0] prop,
  output logic             sec_gen,
  output logic             sec_prop
);
  lah_sop #(.SPAN(BLOCK)) u_sop (
    .gen  (gen),
    .prop (prop),
    .cin  (1'b0),
    .co   (sec_gen)
  );

  assign sec_prop = &prop;

  always_comb begin
    if (!$isunknown({gen, prop, sec_gen, sec_prop})) begin
      // R4: a generate in the top group always yields a section generate
      assert_top_gen_R4 : assert (!gen[BLOCK-1] || sec_gen)
        else $error("section generate low under top-group generate");
      // R4: top group killing means no section generate
      assert_top_kill_R4 : assert (gen[BLOCK-1] || prop[BLOCK-1] || !sec_gen)
        else $error("section generate high under top-group kill");
      // R5: section propagate needs the lowest group to propagate
      assert_prop_low_R5 : assert (!sec_prop || prop[0])
        else $error("section propagate without group 0 propagate");
    end
  end
endmodule

// File: rtl/lah_gen.sv
module lah_gen #(
  parameter int unsigned BLOCK = lah_pkg::LAH_BLOCK
) (
  input  logic [BLOCK-1:0] gen_i,
  input  logic [BLOCK-1:0] prop_i,
  input  logic             cin_i,
  output logic [BLOCK-1:1] carry_o,
  output logic             sec_gen_o,
  output logic             sec_prop_o
);
  localparam int unsigned NBND = BLOCK - 1;

  lah_carries #(.BLOCK(BLOCK)) u_carries (
    .gen   (gen_i),
    .prop  (prop_i),
    .cin   (cin_i),
    .carry (carry_o)
  );

  lah_section #(.BLOCK(BLOCK)) u_section (
    .gen      (gen_i),
    .prop     (prop_i),
    .sec_gen  (sec_gen_o),
    .sec_prop (sec_prop_o)
  );

  always_comb begin
    assert_block_size : assert (BLOCK >= lah_pkg::LAH_MIN_BLOCK)
      else $error("blocking factor below minimum");
    if (!$isunknown({gen_i, prop_i, cin_i, carry_o, sec_gen_o, sec_prop_o})) begin
      // R7: a pure propagate chain hands cin_i to every boundary
      assert_chain_pass_R7 : assert (!((gen_i == '0) && (&prop_i)) || (carry_o == {NBND{cin_i}}))
        else $error("propagate chain did not pass the incoming carry");
      // R5/R4: with every group propagating, section generate tracks any generate
      assert_sec_pair_R5 : assert (!sec_prop_o || (sec_gen_o == (|gen_i)))
        else $error("section pair inconsistent under full propagate");
    end
  end
endmodule

// File: tb/lah_gen_test.sv
module lah_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int B = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  // single unit under test
  logic [B-1:0] gen, prop;
  logic         cin;
  logic [B-1:1] carry;
  logic         sgen, sprop;

  lah_gen #(.BLOCK(B)) uut (
    .gen_i(gen), .prop_i(prop), .cin_i(cin),
    .carry_o(carry), .sec_gen_o(sgen), .sec_prop_o(sprop)
  );

  // two-level tree over 16 group pairs
  logic [15:0] tg, tp;
  logic        tcin;
  logic [3:0]  lo_gs, lo_ps, lo_cin;
  logic [3:1]  lo_c [4];
  logic [3:1]  hi_c;
  logic        hi_gs, hi_ps;

  assign lo_cin = {hi_c, tcin};

  for (genvar i = 0; i < 4; i++) begin : g_lo
    lah_gen #(.BLOCK(B)) u_lo (
      .gen_i(tg[4*i+3:4*i]), .prop_i(tp[4*i+3:4*i]), .cin_i(lo_cin[i]),
      .carry_o(lo_c[i]), .sec_gen_o(lo_gs[i]), .sec_prop_o(lo_ps[i])
    );
  end

  lah_gen #(.BLOCK(B)) u_hi (
    .gen_i(lo_gs), .prop_i(lo_ps), .cin_i(tcin),
    .carry_o(hi_c), .sec_gen_o(hi_gs), .sec_prop_o(hi_ps)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // carries c[0..16] rippled one pair at a time
  function automatic logic [16:0] ripple16(input logic [15:0] g, input logic [15:0] p, input logic c0);
    logic [16:0] c;
    c[0] = c0;
    for (int i = 0; i < 16; i++) c[i+1] = g[i] | (p[i] & c[i]);
    return c;
  endfunction

  task automatic apply1(input logic [3:0] g, input logic [3:0] p, input logic c);
    @(negedge clk);
    gen = g; prop = p; cin = c;
    @(posedge clk); #1;
  endtask

  task automatic check_tree(input logic [15:0] g, input logic [15:0] p, input logic c);
    logic [16:0] rc, r0;
    @(negedge clk);
    tg = g; tp = p; tcin = c;
    @(posedge clk); #1;
    rc = ripple16(g, p, c);
    r0 = ripple16(g, p, 1'b0);
    chk("R8 top carries", {13'd0, hi_c}, {13'd0, rc[12], rc[8], rc[4]});
    for (int i = 0; i < 4; i++)
      chk("R8 inner carries", {13'd0, lo_c[i]}, {13'd0, rc[4*i+3], rc[4*i+2], rc[4*i+1]});
    chk("R8 top section pair", {14'd0, hi_gs, hi_ps}, {14'd0, r0[16], &p});
  endtask

  logic sg_z [256];
  logic sp_z [256];

  initial begin
    logic [16:0] rc;
    logic [31:0] lfsr;
    gen = '0; prop = '0; cin = 1'b0;
    tg = '0; tp = '0; tcin = 1'b0;
    @(posedge clk); #1;
    // idle state: all-zero inputs give all-zero outputs
    chk("R3 idle outputs", {13'd0, carry, sgen, sprop}, 16'd0);

    // exhaustive single unit: vector bit 8 = cin, bits 7:4 = prop, bits 3:0 = gen
    for (int v = 0; v < 512; v++) begin
      logic [3:0] g, p;
      logic c;
      g = v[3:0]; p = v[7:4]; c = v[8];
      apply1(g, p, c);
      rc = ripple16({12'd0, g}, {12'd0, p}, c);
      chk("R1 boundary carries", {13'd0, carry}, {13'd0, rc[3:1]});
      rc = ripple16({12'd0, g}, {12'd0, p}, 1'b0);
      chk("R4 section generate", {15'd0, sgen}, {15'd0, rc[4]});
      chk("R5 section propagate", {15'd0, sprop}, {15'd0, &p});
      for (int k = 1; k < 4; k++) begin
        if (g[k-1]) chk("R2 generate forces carry", {15'd0, carry[k]}, 16'd1);
        if (!g[k-1] && !p[k-1]) chk("R3 kill clears carry", {15'd0, carry[k]}, 16'd0);
      end
      if (!c) begin
        sg_z[v[7:0]] = sgen;
        sp_z[v[7:0]] = sprop;
      end else begin
        chk("R6 cin ignored by section pair", {14'd0, sgen, sprop}, {14'd0, sg_z[v[7:0]], sp_z[v[7:0]]});
      end
    end

    // pure propagate chain
    apply1(4'h0, 4'hF, 1'b1);
    chk("R7 chain passes cin=1", {13'd0, carry}, 16'h7);
    apply1(4'h0, 4'hF, 1'b0);
    chk("R7 chain passes cin=0", {13'd0, carry}, 16'h0);

    // two-level tree
    check_tree(16'h0000, 16'hFFFF, 1'b1);
    check_tree(16'h0000, 16'hFFFF, 1'b0);
    check_tree(16'h0001, 16'hFFFE, 1'b0);
    check_tree(16'h0000, 16'h0000, 1'b1);
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      check_tree(lfsr[15:0] & ~lfsr[31:16], lfsr[31:16] | (lfsr[15:0] & {16{n[0]}}), lfsr[7]);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule